// File: doc/BRIEF.md
# Semaphore-Driven Descriptor Channel Controller

This block is the command front end of a cipher/hash co-processor. Software talks to it through a small register bank. Each of four channels has a command pointer and a counting semaphore. Software points a channel at a descriptor in memory and then adds to the channel's semaphore. Whenever an enabled, error-free channel has a nonzero count, the controller reads the descriptor through a simple request/acknowledge memory port. It decodes the two control words into job fields, runs the job on an execution engine, and writes a completion code back into the descriptor.

The execution engine is modelled by a stub that reports completion a fixed number of cycles after start. The descriptor chooses two things on completion: whether the channel's count drops by one, and whether the channel's bit in the global status register is set. A nonzero next-address field chains to another descriptor for as long as the count stays nonzero. A memory fault stops the channel and records an error code, which software clears by writing ones.

Top module: `cmd_chan_ctrl`

## Requirements
- R1: After reset every pointer, count, enable, error field and global status bit reads zero, `irq` is low, no memory request is made and no job is active.
- R2: A write to a channel's count register (window offset 0x10) adds `wdata[7:0]` to the channel's count, saturating at 255. A read of that offset returns the count.
- R3: A channel is served only while all of the following hold: its enable bit is set in register 0x20 (bit n for channel n), its count is nonzero, and its error field is zero.
- R4: Ready channels are granted in fixed priority, with channel 0 highest. Only one descriptor is in progress at a time, and it completes before the next grant is made.
- R5: A descriptor is read as seven 32-bit words at pointer+0 through pointer+24, in this order: next address, control 0, control 1, source, destination, length, payload. The memory request and address stay stable until acknowledged.
- R6: The job outputs decode control 0 as follows: bit 5 cipher enable, bit 6 hash enable, bit 8 encrypt, bit 9 cipher init, bit 11 key in payload, bit 12 hash init, bit 13 hash terminate. They decode control 1 as follows: bits [3:0] cipher, bits [7:4] mode, bits [19:16] hash. `job_active` is high for exactly ENG_LAT cycles per descriptor.
- R7: On completion the value 0x1 is written to pointer+28. Control 0 bit 1 then decrements the count by one, and control 0 bit 0 sets the channel's global status bit. `irq` is the OR of the global status bits.
- R8: A nonzero next address is loaded into the channel pointer, and the chain goes on while the count is nonzero. A zero next address keeps the pointer and clears the count to zero.
- R9: Global status reads at 0x10, one bit per channel in bits [3:0]. Writing ones to 0x18 clears the matching bits.
- R10: A memory error on a descriptor read sets the channel status field (window offset 0x20, bits [3:0]) to 1 and sets the channel's global status bit. It leaves the count unchanged, and the channel stays halted. A memory error on the completion write sets the field to 2.
- R11: Writing ones to window offset 0x28 clears the matching status bits, after which a halted channel resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Request accepted |
| mem_err | input | 1 | Access faulted (valid with `mem_ack`) |
| mem_rdata | input | 32 | Read data (valid with `mem_ack`) |
| irq | output | 1 | Any global status bit set |
| job_active | output | 1 | Engine busy with a descriptor |
| job_chan | output | 2 | Channel of the current descriptor |
| job_cipher_en | output | 1 | Cipher enabled |
| job_hash_en | output | 1 | Hash enabled |
| job_encrypt | output | 1 | Encrypt direction |
| job_cipher_init | output | 1 | Cipher state init |
| job_key_in_payload | output | 1 | Payload pointer holds the key |
| job_hash_init | output | 1 | Hash state init |
| job_hash_term | output | 1 | Hash finalize |
| job_cipher_sel | output | 4 | Cipher select |
| job_cipher_mode | output | 4 | Cipher mode |
| job_hash_sel | output | 4 | Hash select |
| job_src | output | 32 | Source address |
| job_dst | output | 32 | Destination address |
| job_len | output | 32 | Byte length |
| job_payload | output | 32 | Payload address |

## Verification
A lone descriptor with decrement and interrupt set shows the basic path: decode, completion write-back, count decrement and raised interrupt. A two-descriptor chain whose first link does not decrement is then compared with a chain whose first link does. The first runs both links and the second stops after one, which separates chaining from semaphore accounting. A channel with a pending count but no enable shows that a nonzero count alone starts nothing. Enabling two pending channels in the same write shows the grant order. A descriptor pointer in a faulting region, checked before and after its status is cleared, separates the halted state from normal idling.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned DESC_WORDS = 7;
    localparam int unsigned ERR_W      = 4;

    // descriptor word order as read from memory
    localparam int unsigned W_NEXT = 0;
    localparam int unsigned W_C0   = 1;
    localparam int unsigned W_C1   = 2;
    localparam int unsigned W_SRC  = 3;
    localparam int unsigned W_DST  = 4;
    localparam int unsigned W_LEN  = 5;
    localparam int unsigned W_PAY  = 6;
    localparam logic [WORD_W-1:0] STAT_OFS = 32'd28;

    // control word 0 bit positions
    localparam int unsigned C0_IRQ    = 0;
    localparam int unsigned C0_DEC    = 1;
    localparam int unsigned C0_CIPHER = 5;
    localparam int unsigned C0_HASH   = 6;
    localparam int unsigned C0_ENC    = 8;
    localparam int unsigned C0_CINIT  = 9;
    localparam int unsigned C0_KEY    = 11;
    localparam int unsigned C0_HINIT  = 12;
    localparam int unsigned C0_HTERM  = 13;

    // register map
    localparam logic [ADDR_W-1:0] GA_STAT  = 12'h010;
    localparam logic [ADDR_W-1:0] GA_STCLR = 12'h018;
    localparam logic [ADDR_W-1:0] GA_CHEN  = 12'h020;
    localparam logic [3:0]        WIN_PAGE = 4'h1;
    localparam logic [5:0]        OFF_PTR   = 6'h00;
    localparam logic [5:0]        OFF_SEMA  = 6'h10;
    localparam logic [5:0]        OFF_STAT  = 6'h20;
    localparam logic [5:0]        OFF_STCLR = 6'h28;

    localparam logic [ERR_W-1:0]  ERR_NONE  = 4'd0;
    localparam logic [ERR_W-1:0]  ERR_FETCH = 4'd1;
    localparam logic [ERR_W-1:0]  ERR_WBACK = 4'd2;
    localparam logic [WORD_W-1:0] DONE_CODE = 32'h1;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_RUN,
        SQ_WAIT,
        SQ_WBACK
    } seq_state_e;

endpackage

// File: rtl/cmdq_prio_arb.sv
module cmdq_prio_arb #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CIW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] gnt,
    output logic [CIW-1:0] gnt_idx,
    output logic           any
);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_lane
            if (g == 0) begin : g_top
                assign gnt[g] = req[g];
            end else begin : g_low
                assign gnt[g] = req[g] & ~(|req[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        gnt_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) gnt_idx = CIW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/cmdq_exec_stub.sv
module cmdq_exec_stub #(
    parameter int unsigned LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(LAT + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } stub_t;

    stub_t q, d;

    always_comb begin
        d = q;
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = CW'(LAT - 1);
        end else if (q.busy) begin
            if (q.cnt == '0) d.busy = 1'b0;
            else             d.cnt  = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.busy && (q.cnt == '0);

    assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned SEMA_W = 8,
    parameter int unsigned CIW    = $clog2(NCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W-1:0]             rdata,
    output logic [NCH-1:0]                ready,
    output logic [NCH-1:0][WORD_W-1:0]    cmdptr,
    input  logic                          cmp_valid,
    input  logic [CIW-1:0]                cmp_chan,
    input  logic                          cmp_dec,
    input  logic                          cmp_irq,
    input  logic [WORD_W-1:0]             cmp_next,
    input  logic                          err_valid,
    input  logic [CIW-1:0]                err_chan,
    input  logic [ERR_W-1:0]              err_code,
    output logic                          irq
);

    typedef struct packed {
        logic [NCH-1:0][WORD_W-1:0] ptr;
        logic [NCH-1:0][SEMA_W-1:0] sema;
        logic [NCH-1:0][ERR_W-1:0]  err;
        logic [NCH-1:0]             gstat;
        logic [NCH-1:0]             chen;
    } regs_t;

    regs_t q, d;

    logic            win_hit;
    logic [CIW-1:0]  win_ch;
    logic [5:0]      win_off;
    logic            sema_wr_any;

    assign win_ch  = addr[6 +: CIW];
    assign win_off = addr[5:0];
    assign win_hit = (addr[11:8] == WIN_PAGE) && (int'(addr[7:6]) < NCH);
    assign sema_wr_any = wr_en && win_hit && (win_off == OFF_SEMA);

    logic [NCH-1:0] ptr_wr, sema_wr, stclr_wr, cmp_hit, err_hit;
    logic [NCH-1:0][SEMA_W:0] cnt_a, cnt_b;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic win_mine;
            assign win_mine    = wr_en && win_hit && (win_ch == CIW'(g));
            assign ptr_wr[g]   = win_mine && (win_off == OFF_PTR);
            assign sema_wr[g]  = win_mine && (win_off == OFF_SEMA);
            assign stclr_wr[g] = win_mine && (win_off == OFF_STCLR);
            assign cmp_hit[g]  = cmp_valid && (cmp_chan == CIW'(g));
            assign err_hit[g]  = err_valid && (err_chan == CIW'(g));
            assign ready[g]    = q.chen[g] && (q.sema[g] != '0) && (q.err[g] == ERR_NONE);
            assign cmdptr[g]   = q.ptr[g];
        end
    endgenerate

    always_comb begin
        d = q;
        if (wr_en && addr == GA_CHEN) d.chen = wdata[NCH-1:0];
        if (wr_en && addr == GA_STCLR) d.gstat = q.gstat & ~wdata[NCH-1:0];
        for (int i = 0; i < NCH; i++) begin
            // count: chain end clears, completion may decrement, software adds
            if (cmp_hit[i] && cmp_next == '0)
                cnt_a[i] = '0;
            else
                cnt_a[i] = {1'b0, q.sema[i]} - (SEMA_W+1)'(cmp_hit[i] && cmp_dec);
            cnt_b[i] = cnt_a[i] + (sema_wr[i] ? {1'b0, wdata[SEMA_W-1:0]} : '0);
            d.sema[i] = cnt_b[i][SEMA_W] ? '1 : cnt_b[i][SEMA_W-1:0];

            if (ptr_wr[i]) d.ptr[i] = wdata;
            if (cmp_hit[i] && cmp_next != '0) d.ptr[i] = cmp_next;

            if (stclr_wr[i]) d.err[i] = q.err[i] & ~wdata[ERR_W-1:0];
            if (err_hit[i])  d.err[i] = err_code;

            if ((cmp_hit[i] && cmp_irq) || err_hit[i]) d.gstat[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        if (addr == GA_STAT) begin
            rdata[NCH-1:0] = q.gstat;
        end else if (addr == GA_CHEN) begin
            rdata[NCH-1:0] = q.chen;
        end else if (win_hit) begin
            case (win_off)
                OFF_PTR:  rdata = q.ptr[win_ch];
                OFF_SEMA: rdata[SEMA_W-1:0] = q.sema[win_ch];
                OFF_STAT: rdata[ERR_W-1:0] = q.err[win_ch];
                default:  rdata = '0;
            endcase
        end
    end

    assign irq = |q.gstat;

    assert_dec_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_dec) |-> (q.sema[cmp_chan] != '0));

    assert_err_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !sema_wr_any) |=> $stable(q.sema));

    assert_err_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> (|q.gstat));

endmodule

// File: rtl/cmd_chan_ctrl.sv
module cmd_chan_ctrl
    import cmdq_pkg::*;
#(
    parameter int unsigned NCH     = 4,
    parameter int unsigned SEMA_W  = 8,
    parameter int unsigned ENG_LAT = 8,
    parameter int unsigned CIW     = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              irq,
    output logic              job_active,
    output logic [CIW-1:0]    job_chan,
    output logic              job_cipher_en,
    output logic              job_hash_en,
    output logic              job_encrypt,
    output logic              job_cipher_init,
    output logic              job_key_in_payload,
    output logic              job_hash_init,
    output logic              job_hash_term,
    output logic [3:0]        job_cipher_sel,
    output logic [3:0]        job_cipher_mode,
    output logic [3:0]        job_hash_sel,
    output logic [31:0]       job_src,
    output logic [31:0]       job_dst,
    output logic [31:0]       job_len,
    output logic [31:0]       job_payload
);

    localparam int unsigned IDX_W = $clog2(DESC_WORDS);

    typedef struct packed {
        seq_state_e                        st;
        logic [CIW-1:0]                    ch;
        logic [WORD_W-1:0]                 base;
        logic [IDX_W-1:0]                  idx;
        logic [DESC_WORDS-1:0][WORD_W-1:0] w;
    } seq_t;

    seq_t q, d;

    logic [NCH-1:0]             chan_ready;
    logic [NCH-1:0][WORD_W-1:0] cmdptr;
    logic [NCH-1:0]             arb_gnt;
    logic [CIW-1:0]             arb_idx;
    logic                       arb_any;
    logic                       eng_start, eng_busy, eng_done;
    logic                       cmp_valid, err_valid;
    logic [ERR_W-1:0]           err_code;

    cmdq_regs #(.NCH(NCH), .SEMA_W(SEMA_W), .CIW(CIW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ready     (chan_ready),
        .cmdptr    (cmdptr),
        .cmp_valid (cmp_valid),
        .cmp_chan  (q.ch),
        .cmp_dec   (q.w[W_C0][C0_DEC]),
        .cmp_irq   (q.w[W_C0][C0_IRQ]),
        .cmp_next  (q.w[W_NEXT]),
        .err_valid (err_valid),
        .err_chan  (q.ch),
        .err_code  (err_code),
        .irq       (irq)
    );

    cmdq_prio_arb #(.NCH(NCH), .CIW(CIW)) i_arb (
        .req     (chan_ready),
        .gnt     (arb_gnt),
        .gnt_idx (arb_idx),
        .any     (arb_any)
    );

    cmdq_exec_stub #(.LAT(ENG_LAT)) i_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .busy  (eng_busy),
        .done  (eng_done)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.base + WORD_W'({q.idx, 2'b00});
        mem_wdata = DONE_CODE;
        eng_start = 1'b0;
        cmp_valid = 1'b0;
        err_valid = 1'b0;
        err_code  = ERR_NONE;
        case (q.st)
            SQ_IDLE: begin
                if (arb_any) begin
                    d.st   = SQ_FETCH;
                    d.ch   = arb_idx;
                    d.base = cmdptr[arb_idx];
                    d.idx  = '0;
                end
            end
            SQ_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (mem_err) begin
                        err_valid = 1'b1;
                        err_code  = ERR_FETCH;
                        d.st      = SQ_IDLE;
                    end else begin
                        d.w[q.idx] = mem_rdata;
                        if (q.idx == IDX_W'(DESC_WORDS - 1)) d.st  = SQ_RUN;
                        else                                 d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            SQ_RUN: begin
                eng_start = 1'b1;
                d.st      = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (eng_done) d.st = SQ_WBACK;
            end
            SQ_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.base + STAT_OFS;
                if (mem_ack) begin
                    d.st = SQ_IDLE;
                    if (mem_err) begin
                        err_valid = 1'b1;
                        err_code  = ERR_WBACK;
                    end else begin
                        cmp_valid = 1'b1;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign job_active         = eng_busy;
    assign job_chan           = q.ch;
    assign job_cipher_en      = q.w[W_C0][C0_CIPHER];
    assign job_hash_en        = q.w[W_C0][C0_HASH];
    assign job_encrypt        = q.w[W_C0][C0_ENC];
    assign job_cipher_init    = q.w[W_C0][C0_CINIT];
    assign job_key_in_payload = q.w[W_C0][C0_KEY];
    assign job_hash_init      = q.w[W_C0][C0_HINIT];
    assign job_hash_term      = q.w[W_C0][C0_HTERM];
    assign job_cipher_sel     = q.w[W_C1][3:0];
    assign job_cipher_mode    = q.w[W_C1][7:4];
    assign job_hash_sel       = q.w[W_C1][19:16];
    assign job_src            = q.w[W_SRC];
    assign job_dst            = q.w[W_DST];
    assign job_len            = q.w[W_LEN];
    assign job_payload        = q.w[W_PAY];

    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_gnt) && ((arb_gnt & ~chan_ready) == '0));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/test_cmd_chan_ctrl.sv
module test_cmd_chan_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq, job_active;
    logic [1:0]  job_chan;
    logic        job_cipher_en, job_hash_en, job_encrypt, job_cipher_init;
    logic        job_key_in_payload, job_hash_init, job_hash_term;
    logic [3:0]  job_cipher_sel, job_cipher_mode, job_hash_sel;
    logic [31:0] job_src, job_dst, job_len, job_payload;

    localparam int LAT = 8;

    cmd_chan_ctrl #(.NCH(4), .SEMA_W(8), .ENG_LAT(LAT)) i_cmd_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq),
        .job_active(job_active), .job_chan(job_chan), .job_cipher_en(job_cipher_en),
        .job_hash_en(job_hash_en), .job_encrypt(job_encrypt),
        .job_cipher_init(job_cipher_init), .job_key_in_payload(job_key_in_payload),
        .job_hash_init(job_hash_init), .job_hash_term(job_hash_term),
        .job_cipher_sel(job_cipher_sel), .job_cipher_mode(job_cipher_mode),
        .job_hash_sel(job_hash_sel), .job_src(job_src), .job_dst(job_dst),
        .job_len(job_len), .job_payload(job_payload)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] mem [64];

    // job log filled by the monitor
    int          n_jobs = 0;
    logic [1:0]  log_chan [32];
    logic [6:0]  log_flags [32];
    logic [3:0]  log_mode [32];
    logic [3:0]  log_hsel [32];
    logic [31:0] log_len [32];
    int          log_cyc [32];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // memory model: answers the current request at every falling edge
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                mem_ack = 1'b1;
                mem_err = (mem_addr >= 32'hFFFF_0000);
                mem_rdata = mem_err ? 32'h0 : mem[mem_addr[7:2]];
                if (mem_we && !mem_err) mem[mem_addr[7:2]] = mem_wdata;
            end else begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end
        end
    end

    // job monitor
    initial begin
        bit prev = 1'b0;
        forever begin
            @(negedge clk);
            if (job_active && !prev && n_jobs < 32) begin
                log_chan[n_jobs]  = job_chan;
                log_flags[n_jobs] = {job_hash_term, job_hash_init, job_key_in_payload,
                                     job_cipher_init, job_encrypt, job_hash_en, job_cipher_en};
                log_mode[n_jobs]  = job_cipher_mode;
                log_hsel[n_jobs]  = job_hash_sel;
                log_len[n_jobs]   = job_len;
                log_cyc[n_jobs]   = 0;
                n_jobs++;
            end
            if (job_active && n_jobs > 0) log_cyc[n_jobs-1]++;
            prev = job_active;
        end
    end

    task automatic reg_write(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_desc(input int base, input logic [31:0] nxt, input logic [31:0] c0,
                            input logic [31:0] c1, input logic [31:0] len);
        mem[base/4 + 0] = nxt;
        mem[base/4 + 1] = c0;
        mem[base/4 + 2] = c1;
        mem[base/4 + 3] = 32'h0000_1000;
        mem[base/4 + 4] = 32'h0000_2000;
        mem[base/4 + 5] = len;
        mem[base/4 + 6] = 32'h0000_3000;
        mem[base/4 + 7] = 32'h0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(12'h010, v); check("R1", "global status", v, 0);
        reg_read(12'h110, v); check("R1", "ch0 count", v, 0);
        reg_read(12'h100, v); check("R1", "ch0 pointer", v, 0);
        reg_read(12'h020, v); check("R1", "enables", v, 0);
        check("R1", "irq/req/active", {29'd0, irq, mem_req, job_active}, 0);
    endtask

    task automatic t_single;
        logic [31:0] v;
        int j0 = n_jobs;
        put_desc(32'h00, 32'h0, 32'h0000_0B23, 32'h0000_0010, 32'h40);
        reg_write(12'h100, 32'h00);
        reg_write(12'h020, 32'h1);
        reg_write(12'h110, 32'h1);
        settle(60);
        check("R5", "jobs run", n_jobs - j0, 1);
        check("R6", "flags decode", {25'd0, log_flags[j0]}, 32'h1D);
        check("R6", "mode CBC", {28'd0, log_mode[j0]}, 1);
        check("R5", "length word", log_len[j0], 32'h40);
        check("R6", "active cycles", log_cyc[j0], LAT);
        check("R7", "status word written", mem[7], 32'h1);
        reg_read(12'h110, v); check("R7", "count after dec", v, 0);
        reg_read(12'h010, v); check("R7", "global bit ch0", v, 1);
        check("R7", "irq high", {31'd0, irq}, 1);
    endtask

    task automatic t_clear_gstat;
        logic [31:0] v;
        reg_write(12'h018, 32'h1);
        reg_read(12'h010, v); check("R9", "global after clear", v, 0);
        check("R9", "irq low", {31'd0, irq}, 0);
    endtask

    task automatic t_chain;
        logic [31:0] v;
        int j0 = n_jobs;
        put_desc(32'h20, 32'h40, 32'h0000_1040, 32'h0002_0000, 32'h10);
        put_desc(32'h40, 32'h0,  32'h0000_2043, 32'h0002_0000, 32'h20);
        reg_write(12'h100, 32'h20);
        reg_write(12'h110, 32'h1);
        settle(100);
        check("R8", "chain length (first link keeps count)", n_jobs - j0, 2);
        check("R6", "flags link A", {25'd0, log_flags[j0]}, 32'h22);
        check("R6", "flags link B", {25'd0, log_flags[j0+1]}, 32'h42);
        check("R6", "hash select", {28'd0, log_hsel[j0+1]}, 2);
        reg_read(12'h100, v); check("R8", "pointer follows chain", v, 32'h40);
        reg_read(12'h110, v); check("R8", "count at chain end", v, 0);
        reg_read(12'h010, v); check("R7", "irq from link B", v, 1);
        reg_write(12'h018, 32'hF);
    endtask

    task automatic t_chain_stop;
        logic [31:0] v;
        int j0 = n_jobs;
        put_desc(32'h60, 32'h80, 32'h0000_0022, 32'h0, 32'h30);
        put_desc(32'h80, 32'h0,  32'h0000_0023, 32'h0, 32'h30);
        reg_write(12'h100, 32'h60);
        reg_write(12'h110, 32'h1);
        settle(80);
        check("R7", "count exhausted stops chain", n_jobs - j0, 1);
        reg_read(12'h100, v); check("R8", "pointer at next", v, 32'h80);
        reg_read(12'h110, v); check("R7", "count zero", v, 0);
        reg_read(12'h010, v); check("R7", "no irq bit", v, 0);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        int j0 = n_jobs;
        reg_write(12'h140, 32'h00);
        reg_write(12'h150, 32'h2);
        reg_write(12'h150, 32'h1);
        reg_read(12'h150, v); check("R2", "count accumulates", v, 3);
        reg_write(12'h150, 32'hFF);
        reg_read(12'h150, v); check("R2", "count saturates", v, 255);
        settle(60);
        check("R3", "disabled channel idle", n_jobs - j0, 0);
        reg_read(12'h150, v); check("R3", "count untouched", v, 255);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        int j0 = n_jobs;
        put_desc(32'hA0, 32'h0, 32'h0000_0023, 32'h0, 32'h50);
        reg_write(12'h180, 32'hA0);
        reg_write(12'h190, 32'h1);
        reg_write(12'h020, 32'h7);
        settle(120);
        check("R4", "two jobs", n_jobs - j0, 2);
        check("R4", "first grant ch1", {30'd0, log_chan[j0]}, 1);
        check("R4", "second grant ch2", {30'd0, log_chan[j0+1]}, 2);
        reg_read(12'h150, v); check("R8", "ch1 count cleared at chain end", v, 0);
        reg_read(12'h190, v); check("R7", "ch2 count", v, 0);
        reg_write(12'h018, 32'hF);
    endtask

    task automatic t_error;
        logic [31:0] v;
        int j0 = n_jobs;
        reg_write(12'h1C0, 32'hFFFF_0000);
        reg_write(12'h020, 32'hF);
        reg_write(12'h1D0, 32'h1);
        settle(40);
        reg_read(12'h1E0, v); check("R10", "fetch error code", v, 1);
        reg_read(12'h010, v); check("R10", "global bit ch3", v, 32'h8);
        reg_read(12'h1D0, v); check("R10", "count kept", v, 1);
        settle(40);
        check("R10", "halted channel idle", n_jobs - j0, 0);
        reg_write(12'h1C0, 32'hA0);
        reg_write(12'h1E8, 32'hFFFF_FFFF);
        settle(60);
        reg_read(12'h1E0, v); check("R11", "status cleared", v, 0);
        check("R11", "channel resumed", n_jobs - j0, 1);
        check("R11", "resumed on ch3", {30'd0, log_chan[j0]}, 3);
        reg_read(12'h1D0, v); check("R11", "count consumed", v, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_clear_gstat();
        t_chain();
        t_chain_stop();
        t_disabled();
        t_priority();
        t_error();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule